// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block caches virtual-to-physical page translations for a processor's memory pipeline. Every slot can hold any translation. A lookup compares the requested virtual page number and the current address-space tag against all slots at once. One cycle later the block reports one of three results. A permitted hit returns the physical address. A hit on a page that forbids the access type returns a protection fault. No match returns a miss, and a hardware walker or a software trap then fetches the page-table entry. Because every slot carries its own address-space tag, translations of several processes can sit side by side and a context switch needs no flush.

Writes come in through an insert port and are accepted only while the privileged-mode input is high. An insert that repeats a resident page/tag pair updates that slot in place. Otherwise it takes the lowest free ordinary slot. When no ordinary slot is free, it evicts a victim chosen by least-recently-used order or by a free-running pseudo-random sequence, according to a configuration input. The lowest slots are reserved for pinned translations: neither replacement nor flushing removes them. A privileged flush clears every ordinary slot in one cycle, or only those tagged with one address space.

Top module: `asid_tlb`

## Requirements
- R1: After reset no slot is valid, so every lookup reports a miss.
- R2: The result of a lookup appears on the cycle after `lkValid` and stays there for one cycle. Exactly one of `lkHit`, `lkMiss`, `lkFault` is high on that cycle. All three are low on a cycle whose previous cycle had no lookup.
- R3: A slot matches only when its page number and its address-space tag both equal the request. The same page under another tag misses.
- R4: On a permitted hit, `lkPaddr` is the slot's frame number with the 12 offset bits of the request below it. On a miss or a fault, `lkPaddr` is zero.
- R5: The access code selects one permission bit of the slot: 0 is read (bit 0), 1 is write (bit 1), 2 is execute (bit 2). Code 3 is never permitted. If the selected bit is clear, the result is a fault and not a hit.
- R6: On a permitted hit, `lkDirty` reports the slot's dirty bit. That bit is loaded from `insDirty` at insert time and is set by any permitted write hit, so later lookups report it as set.
- R7: Inserts and flushes take effect only while `privMode` is high. Without it they change nothing.
- R8: An ordinary insert whose page/tag pair is already resident overwrites that slot. It creates no second copy and evicts no other slot.
- R9: An ordinary insert with no resident match takes the lowest-numbered free ordinary slot before any eviction.
- R10: With `cfgRandom` low and all ordinary slots full, an insert evicts the ordinary slot that was least recently looked up or written.
- R11: With `cfgRandom` high and all ordinary slots full, an insert evicts a pseudo-randomly chosen ordinary slot. A reserved slot is never chosen.
- R12: A pinned insert (`insPin` high) writes reserved slot `insSlot` when `insSlot` is below the reserved count, and is ignored otherwise. Reserved slots survive flushes and replacement.
- R13: `flushAll` invalidates every ordinary slot in one cycle. `flushByAsid` invalidates only the ordinary slots whose tag equals `flushAsid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgRandom | input | 1 | Replacement policy: 0 least-recently-used, 1 pseudo-random |
| privMode | input | 1 | Privileged mode; enables inserts and flushes |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 32 | Virtual address (page number above 12 offset bits) |
| lkAsid | input | 6 | Current address-space tag |
| lkAccess | input | 2 | Access code: 0 read, 1 write, 2 execute |
| lkHit | output | 1 | Permitted hit |
| lkMiss | output | 1 | No matching slot |
| lkFault | output | 1 | Match without permission |
| lkDirty | output | 1 | Dirty bit of the hit slot |
| lkPaddr | output | 32 | Physical address on a permitted hit |
| insValid | input | 1 | Insert request |
| insPin | input | 1 | Insert into a reserved slot |
| insSlot | input | 3 | Reserved slot index for a pinned insert |
| insVpn | input | 20 | Page number to insert |
| insAsid | input | 6 | Address-space tag to insert |
| insPfn | input | 20 | Frame number to insert |
| insPerm | input | 3 | Permissions {execute, write, read} |
| insDirty | input | 1 | Initial dirty bit |
| flushAll | input | 1 | Invalidate all ordinary slots |
| flushByAsid | input | 1 | Invalidate ordinary slots of one tag |
| flushAsid | input | 6 | Tag for a tag-selective flush |

## Verification
The lookup path is driven with matching page and tag, matching page under a foreign tag, and unknown pages, which separates a true associative match from a page-only compare. Each access code is applied to pages with partial permissions, so that a fault shows up where a hit would be wrong and the zeroed address is visible. Replacement is exercised with a fixed touch order, so that the least-recently-used victim is one known slot and the other five stay resident. A long run of random-policy inserts then checks that exactly as many translations survive as there are ordinary slots while the pinned ones stay. Unprivileged writes, flushes and out-of-range pinned inserts are each followed by lookups that would expose any change.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Access code carried on the lookup port
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } accType_t;

  // Strobes from control to the slot array
  typedef struct packed {
    logic wrEn;     // write slot wrIdx with the insert fields
    logic clrAll;   // drop every ordinary slot
    logic clrAsid;  // drop ordinary slots of one tag
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PINNED  = 2,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 6,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  tlbStrobe_t                strobe,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic [VPN_W-1:0]          insVpn,
  input  logic [ASID_W-1:0]         insAsid,
  input  logic [PFN_W-1:0]          insPfn,
  input  logic [2:0]                insPerm,
  input  logic                      insDirty,
  input  logic [ASID_W-1:0]         flushAsid,
  input  logic                      lkValid,
  input  logic [VPN_W+OFF_W-1:0]    lkVaddr,
  input  logic [ASID_W-1:0]         lkAsid,
  input  logic [1:0]                lkAccess,
  output logic                      matchAny,
  output logic [IDX_W-1:0]          matchIdx,
  output logic                      dupAny,
  output logic [IDX_W-1:0]          dupIdx,
  output logic [ENTRIES-1:0]        validVec,
  output logic                      lkHit,
  output logic                      lkMiss,
  output logic                      lkFault,
  output logic                      lkDirty,
  output logic [PFN_W+OFF_W-1:0]    lkPaddr
);

  logic [ENTRIES-1:0] valid;
  logic [ENTRIES-1:0] dirty;
  logic [VPN_W-1:0]   vpnQ  [ENTRIES];
  logic [PFN_W-1:0]   pfnQ  [ENTRIES];
  logic [ASID_W-1:0]  asidQ [ENTRIES];
  logic [2:0]         permQ [ENTRIES];

  logic [VPN_W-1:0]   lkVpn;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] dupMatch;
  logic [2:0]         needMask;
  logic               permOk;
  logic               markDirty;

  assign lkVpn    = lkVaddr[VPN_W+OFF_W-1:OFF_W];
  assign validVec = valid;

  // Parallel compare of every slot against lookup and insert keys
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lkMatch[g]  = valid[g] && (vpnQ[g] == lkVpn)  && (asidQ[g] == lkAsid);
    assign dupMatch[g] = valid[g] && (vpnQ[g] == insVpn) && (asidQ[g] == insAsid);
  end

  always_comb begin
    matchIdx = '0;
    dupIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i])  matchIdx = IDX_W'(i);
      if (dupMatch[i]) dupIdx   = IDX_W'(i);
    end
  end

  assign matchAny = |lkMatch;
  assign dupAny   = |dupMatch;

  always_comb begin
    unique case (accType_t'(lkAccess))
      ACC_READ:  needMask = 3'b001;
      ACC_WRITE: needMask = 3'b010;
      ACC_EXEC:  needMask = 3'b100;
      default:   needMask = 3'b000;
    endcase
  end

  assign permOk    = |(permQ[matchIdx] & needMask);
  assign markDirty = lkValid && matchAny && permOk && (accType_t'(lkAccess) == ACC_WRITE);

  // Slot array: flush first, then dirty marking, then the write wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      dirty <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i]  <= '0;
        pfnQ[i]  <= '0;
        asidQ[i] <= '0;
        permQ[i] <= '0;
      end
    end else begin
      for (int i = PINNED; i < ENTRIES; i++) begin
        if (strobe.clrAll || (strobe.clrAsid && (asidQ[i] == flushAsid)))
          valid[i] <= 1'b0;
      end
      if (markDirty)
        dirty[matchIdx] <= 1'b1;
      if (strobe.wrEn) begin
        valid[wrIdx] <= 1'b1;
        dirty[wrIdx] <= insDirty;
        vpnQ[wrIdx]  <= insVpn;
        pfnQ[wrIdx]  <= insPfn;
        asidQ[wrIdx] <= insAsid;
        permQ[wrIdx] <= insPerm;
      end
    end
  end

  // Registered lookup result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lkHit   <= 1'b0;
      lkMiss  <= 1'b0;
      lkFault <= 1'b0;
      lkDirty <= 1'b0;
      lkPaddr <= '0;
    end else begin
      lkHit   <= lkValid && matchAny && permOk;
      lkFault <= lkValid && matchAny && !permOk;
      lkMiss  <= lkValid && !matchAny;
      lkDirty <= lkValid && matchAny && permOk && dirty[matchIdx];
      lkPaddr <= (lkValid && matchAny && permOk) ?
                 {pfnQ[matchIdx], lkVaddr[OFF_W-1:0]} : '0;
    end
  end

  // R2
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lkHit, lkMiss, lkFault}));

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkValid |=> (lkHit || lkMiss || lkFault));

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkHit |-> (lkPaddr[OFF_W-1:0] == $past(lkVaddr[OFF_W-1:0])));

  // R4
  paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkHit |-> (lkPaddr == '0));

  // R12
  for (genvar p = 0; p < PINNED; p++) begin : g_pinChk
    pinned_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(valid[p]));
  end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PINNED  = 2,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgRandom,
  input  logic               privMode,
  input  logic               insValid,
  input  logic               insPin,
  input  logic [IDX_W-1:0]   insSlot,
  input  logic               flushAll,
  input  logic               flushByAsid,
  input  logic               lkValid,
  input  logic               matchAny,
  input  logic [IDX_W-1:0]   matchIdx,
  input  logic               dupAny,
  input  logic [IDX_W-1:0]   dupIdx,
  input  logic [ENTRIES-1:0] validVec,
  output tlbStrobe_t         strobe,
  output logic [IDX_W-1:0]   wrIdx
);

  // ENTRIES is a power of two and PINNED is at most ENTRIES/2
  localparam int               LFSR_W   = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAP = 16'hB400;
  localparam logic [IDX_W-1:0] PIN_IDX  = IDX_W'(PINNED);
  localparam logic [IDX_W-1:0] WRAP_IDX = IDX_W'(ENTRIES - PINNED);

  logic [LFSR_W-1:0] lfsr;
  logic [IDX_W-1:0]  age [ENTRIES];

  logic              pinGo, normGo;
  logic              freeAny;
  logic [IDX_W-1:0]  freeIdx, lruIdx, rndRaw, rndIdx;
  logic [IDX_W-1:0]  bestAge;
  logic              touchEn;
  logic [IDX_W-1:0]  touchIdx, touchAge;

  assign pinGo  = insValid && privMode && insPin && (insSlot < PIN_IDX);
  assign normGo = insValid && privMode && !insPin;

  // Lowest free ordinary slot
  always_comb begin
    freeAny = 1'b0;
    freeIdx = PIN_IDX;
    for (int i = ENTRIES - 1; i >= PINNED; i--) begin
      if (!validVec[i]) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  // Oldest ordinary slot; ages form a permutation so the oldest is unique
  always_comb begin
    lruIdx  = PIN_IDX;
    bestAge = age[PINNED];
    for (int i = PINNED; i < ENTRIES; i++) begin
      if (age[i] > bestAge) begin
        bestAge = age[i];
        lruIdx  = IDX_W'(i);
      end
    end
  end

  // Fold the whole LFSR state into an index, then move it off the reserved range
  always_comb begin
    rndRaw = '0;
    for (int b = 0; b < LFSR_W; b++)
      rndRaw[b % IDX_W] = rndRaw[b % IDX_W] ^ lfsr[b];
    rndIdx = (rndRaw < PIN_IDX) ? rndRaw + WRAP_IDX : rndRaw;
  end

  always_comb begin
    if (pinGo)        wrIdx = insSlot;
    else if (dupAny)  wrIdx = dupIdx;
    else if (freeAny) wrIdx = freeIdx;
    else if (cfgRandom) wrIdx = rndIdx;
    else              wrIdx = lruIdx;
  end

  always_comb begin
    strobe.wrEn    = pinGo || normGo;
    strobe.clrAll  = flushAll && privMode;
    strobe.clrAsid = flushByAsid && privMode;
  end

  assign touchEn  = strobe.wrEn || (lkValid && matchAny);
  assign touchIdx = strobe.wrEn ? wrIdx : matchIdx;
  assign touchAge = age[touchIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= 16'hACE1;
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else begin
      lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAP : '0);
      if (touchEn) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touchIdx)  age[i] <= '0;
          else if (age[i] < touchAge) age[i] <= age[i] + IDX_W'(1);
        end
      end
    end
  end

  // R7
  write_needs_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn || strobe.clrAll || strobe.clrAsid) |-> privMode);

  // R11
  victim_not_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && !insPin) |-> (wrIdx >= PIN_IDX));

  // R12
  pin_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && insPin) |-> (wrIdx < PIN_IDX));

  // R11
  lfsr_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PINNED  = 2,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 6,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgRandom,
  input  logic              privMode,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [1:0]        lkAccess,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkFault,
  output logic              lkDirty,
  output logic [PA_W-1:0]   lkPaddr,
  input  logic              insValid,
  input  logic              insPin,
  input  logic [IDX_W-1:0]  insSlot,
  input  logic [VPN_W-1:0]  insVpn,
  input  logic [ASID_W-1:0] insAsid,
  input  logic [PFN_W-1:0]  insPfn,
  input  logic [2:0]        insPerm,
  input  logic              insDirty,
  input  logic              flushAll,
  input  logic              flushByAsid,
  input  logic [ASID_W-1:0] flushAsid
);

  tlbStrobe_t         strobe;
  logic [IDX_W-1:0]   wrIdx;
  logic               matchAny, dupAny;
  logic [IDX_W-1:0]   matchIdx, dupIdx;
  logic [ENTRIES-1:0] validVec;

  tlb_ctrl #(
    .ENTRIES(ENTRIES), .PINNED(PINNED), .IDX_W(IDX_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgRandom(cfgRandom), .privMode(privMode),
    .insValid(insValid), .insPin(insPin), .insSlot(insSlot),
    .flushAll(flushAll), .flushByAsid(flushByAsid),
    .lkValid(lkValid), .matchAny(matchAny), .matchIdx(matchIdx),
    .dupAny(dupAny), .dupIdx(dupIdx), .validVec(validVec),
    .strobe(strobe), .wrIdx(wrIdx)
  );

  tlb_datapath #(
    .ENTRIES(ENTRIES), .PINNED(PINNED), .VPN_W(VPN_W), .PFN_W(PFN_W),
    .ASID_W(ASID_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrIdx(wrIdx),
    .insVpn(insVpn), .insAsid(insAsid), .insPfn(insPfn), .insPerm(insPerm),
    .insDirty(insDirty), .flushAsid(flushAsid),
    .lkValid(lkValid), .lkVaddr(lkVaddr), .lkAsid(lkAsid), .lkAccess(lkAccess),
    .matchAny(matchAny), .matchIdx(matchIdx), .dupAny(dupAny), .dupIdx(dupIdx),
    .validVec(validVec),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkFault(lkFault), .lkDirty(lkDirty),
    .lkPaddr(lkPaddr)
  );

endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgRandom = 1'b0, privMode = 1'b0;
  logic        lkValid = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic [5:0]  lkAsid = '0;
  logic [1:0]  lkAccess = '0;
  logic        lkHit, lkMiss, lkFault, lkDirty;
  logic [31:0] lkPaddr;
  logic        insValid = 1'b0, insPin = 1'b0, insDirty = 1'b0;
  logic [2:0]  insSlot = '0, insPerm = '0;
  logic [19:0] insVpn = '0, insPfn = '0;
  logic [5:0]  insAsid = '0;
  logic        flushAll = 1'b0, flushByAsid = 1'b0;
  logic [5:0]  flushAsid = '0;

  int checks = 0;
  int errors = 0;
  logic        rHit, rMiss, rFault, rDirty;
  logic [31:0] rPaddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb i_asid_tlb (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic lookup(logic [19:0] vpn, logic [11:0] off, logic [5:0] asid, logic [1:0] acc);
    @(negedge clk);
    lkValid = 1'b1; lkVaddr = {vpn, off}; lkAsid = asid; lkAccess = acc;
    @(negedge clk);
    lkValid = 1'b0;
    rHit = lkHit; rMiss = lkMiss; rFault = lkFault; rDirty = lkDirty; rPaddr = lkPaddr;
  endtask

  task automatic insert(logic [19:0] vpn, logic [5:0] asid, logic [19:0] pfn,
                        logic [2:0] perm, logic dty, logic priv, logic pin, logic [2:0] slot);
    @(negedge clk);
    insValid = 1'b1; insVpn = vpn; insAsid = asid; insPfn = pfn; insPerm = perm;
    insDirty = dty; privMode = priv; insPin = pin; insSlot = slot;
    @(negedge clk);
    insValid = 1'b0; privMode = 1'b0; insPin = 1'b0;
  endtask

  task automatic flush(logic all, logic byAsid, logic [5:0] asid, logic priv);
    @(negedge clk);
    flushAll = all; flushByAsid = byAsid; flushAsid = asid; privMode = priv;
    @(negedge clk);
    flushAll = 1'b0; flushByAsid = 1'b0; privMode = 1'b0;
  endtask

  task automatic expectHit(string req, logic [19:0] vpn, logic [5:0] asid, logic [19:0] pfn);
    lookup(vpn, 12'h5A4, asid, 2'd0);
    check(req, {31'd0, rHit}, 32'd1, "hit");
    check(req, rPaddr, {pfn, 12'h5A4}, "paddr");
  endtask

  task automatic expectMiss(string req, logic [19:0] vpn, logic [5:0] asid);
    lookup(vpn, 12'h010, asid, 2'd0);
    check(req, {29'd0, rHit, rMiss, rFault}, 32'b010, "hit/miss/fault");
  endtask

  task automatic testReset();
    check("R1", {28'd0, lkHit, lkMiss, lkFault, lkDirty}, 32'd0, "idle outputs");
    expectMiss("R1", 20'h00000, 6'd0);
    expectMiss("R2", 20'h12345, 6'd3);
    @(negedge clk);
    check("R2", {29'd0, lkHit, lkMiss, lkFault}, 32'd0, "outputs clear without request");
  endtask

  task automatic testBasic();
    insert(20'h12345, 6'd3, 20'hABCDE, 3'b111, 1'b0, 1'b1, 1'b0, 3'd0);
    lookup(20'h12345, 12'h7A9, 6'd3, 2'd0);
    check("R4", rPaddr, 32'hABCDE7A9, "translated address");
    check("R2", {29'd0, rHit, rMiss, rFault}, 32'b100, "one-hot hit");
    expectMiss("R3", 20'h12345, 6'd4);
    expectMiss("R3", 20'h12346, 6'd3);
  endtask

  task automatic testPerm();
    insert(20'h00100, 6'd1, 20'h0F00F, 3'b001, 1'b0, 1'b1, 1'b0, 3'd0);
    lookup(20'h00100, 12'h004, 6'd1, 2'd0);
    check("R5", {31'd0, rHit}, 32'd1, "read permitted");
    lookup(20'h00100, 12'h004, 6'd1, 2'd1);
    check("R5", {29'd0, rHit, rMiss, rFault}, 32'b001, "write fault");
    check("R4", rPaddr, 32'd0, "fault address zero");
    lookup(20'h00100, 12'h004, 6'd1, 2'd2);
    check("R5", {31'd0, rFault}, 32'd1, "exec fault");
    insert(20'h00200, 6'd1, 20'h0A0A0, 3'b111, 1'b0, 1'b1, 1'b0, 3'd0);
    lookup(20'h00200, 12'h004, 6'd1, 2'd3);
    check("R5", {31'd0, rFault}, 32'd1, "code 3 never permitted");
    lookup(20'h00200, 12'h004, 6'd1, 2'd2);
    check("R5", {31'd0, rHit}, 32'd1, "exec permitted");
  endtask

  task automatic testDirty();
    insert(20'h00300, 6'd1, 20'h03030, 3'b011, 1'b0, 1'b1, 1'b0, 3'd0);
    lookup(20'h00300, 12'h000, 6'd1, 2'd0);
    check("R6", {31'd0, rDirty}, 32'd0, "clean before write");
    lookup(20'h00300, 12'h000, 6'd1, 2'd1);
    check("R6", {31'd0, rHit}, 32'd1, "write hit");
    lookup(20'h00300, 12'h000, 6'd1, 2'd0);
    check("R6", {31'd0, rDirty}, 32'd1, "dirty after write");
    insert(20'h00400, 6'd1, 20'h04040, 3'b001, 1'b1, 1'b1, 1'b0, 3'd0);
    lookup(20'h00400, 12'h000, 6'd1, 2'd0);
    check("R6", {31'd0, rDirty}, 32'd1, "dirty loaded on insert");
  endtask

  task automatic testPriv();
    insert(20'h00500, 6'd1, 20'h05050, 3'b111, 1'b0, 1'b0, 1'b0, 3'd0);
    expectMiss("R7", 20'h00500, 6'd1);
    flush(1'b1, 1'b0, 6'd0, 1'b0);
    expectHit("R7", 20'h12345, 6'd3, 20'hABCDE);
  endtask

  task automatic testDup();
    insert(20'h12345, 6'd3, 20'h11111, 3'b111, 1'b0, 1'b1, 1'b0, 3'd0);
    expectHit("R8", 20'h12345, 6'd3, 20'h11111);
    // slots 2..6 hold 5 translations; one free slot left, so a new entry plus
    // all old ones must still be resident
    insert(20'h00600, 6'd1, 20'h06060, 3'b111, 1'b0, 1'b1, 1'b0, 3'd0);
    expectHit("R8", 20'h00100, 6'd1, 20'h0F00F);
    expectHit("R8", 20'h00200, 6'd1, 20'h0A0A0);
    expectHit("R8", 20'h00600, 6'd1, 20'h06060);
    expectHit("R8", 20'h00400, 6'd1, 20'h04040);
  endtask

  task automatic testFlush();
    flush(1'b0, 1'b1, 6'd3, 1'b1);
    expectMiss("R13", 20'h12345, 6'd3);
    expectHit("R13", 20'h00100, 6'd1, 20'h0F00F);
    flush(1'b1, 1'b0, 6'd0, 1'b1);
    expectMiss("R13", 20'h00100, 6'd1);
    expectMiss("R13", 20'h00600, 6'd1);
  endtask

  task automatic testPinned();
    insert(20'h70000, 6'd0, 20'h77777, 3'b101, 1'b0, 1'b1, 1'b1, 3'd0);
    insert(20'h70001, 6'd9, 20'h77778, 3'b111, 1'b0, 1'b1, 1'b1, 3'd1);
    insert(20'h70002, 6'd0, 20'h77779, 3'b111, 1'b0, 1'b1, 1'b1, 3'd5);
    expectMiss("R12", 20'h70002, 6'd0);
    flush(1'b1, 1'b0, 6'd0, 1'b1);
    flush(1'b0, 1'b1, 6'd9, 1'b1);
    expectHit("R12", 20'h70000, 6'd0, 20'h77777);
    expectHit("R12", 20'h70001, 6'd9, 20'h77778);
  endtask

  task automatic testLru();
    cfgRandom = 1'b0;
    for (int k = 0; k < 6; k++)
      insert(20'h00200 + 20'(k), 6'd2, 20'h20000 + 20'(k), 3'b111, 1'b0, 1'b1, 1'b0, 3'd0);
    for (int k = 0; k < 6; k++)
      expectHit("R9", 20'h00200 + 20'(k), 6'd2, 20'h20000 + 20'(k));
    expectHit("R10", 20'h00200, 6'd2, 20'h20000);
    insert(20'h002FF, 6'd2, 20'h2FFFF, 3'b111, 1'b0, 1'b1, 1'b0, 3'd0);
    expectMiss("R10", 20'h00201, 6'd2);
    expectHit("R10", 20'h002FF, 6'd2, 20'h2FFFF);
    expectHit("R10", 20'h00200, 6'd2, 20'h20000);
    for (int k = 2; k < 6; k++)
      expectHit("R10", 20'h00200 + 20'(k), 6'd2, 20'h20000 + 20'(k));
  endtask

  task automatic testRandom();
    int hits;
    cfgRandom = 1'b1;
    for (int k = 0; k < 20; k++)
      insert(20'h00300 + 20'(k), 6'd4, 20'h30000 + 20'(k), 3'b111, 1'b0, 1'b1, 1'b0, 3'd0);
    cfgRandom = 1'b0;
    expectHit("R11", 20'h70000, 6'd0, 20'h77777);
    expectHit("R11", 20'h70001, 6'd9, 20'h77778);
    expectHit("R11", 20'h00313, 6'd4, 20'h30013);
    hits = 0;
    for (int k = 0; k < 20; k++) begin
      lookup(20'h00300 + 20'(k), 12'h0, 6'd4, 2'd0);
      if (rHit) hits++;
    end
    lookup(20'h002FF, 12'h0, 6'd2, 2'd0);
    if (rHit) hits++;
    lookup(20'h00200, 12'h0, 6'd2, 2'd0);
    if (rHit) hits++;
    for (int k = 2; k < 6; k++) begin
      lookup(20'h00200 + 20'(k), 12'h0, 6'd2, 2'd0);
      if (rHit) hits++;
    end
    check("R11", 32'(hits), 32'd6, "resident ordinary translations");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testPerm();
    testDirty();
    testPriv();
    testDup();
    testFlush();
    testPinned();
    testLru();
    testRandom();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule